// File: doc/BRIEF.md
# Double-Buffered Capture DMA Channel Registers

This block holds the buffer-programming registers for every channel of a frame-capture DMA engine. Software writes a channel's control word, buffer length, line stride and 64-bit buffer address into shadow copies. The low half of the address is the trigger. Writing it moves the whole shadow set into the active copy that the DMA datapath reads: control, upper address, lower address, stride and length together. If the channel is idle, this transfer happens at once. If a frame is being captured, the set is parked as pending and takes effect at the next frame-start pulse. Address, stride and length count 16-byte units, so software writes byte quantities shifted right by four.

Each channel has a 64-byte window. The first window starts at byte offset 0x28, and the next channel's window starts 0x40 further on. A channel tracks two flags. The armed flag means a buffer is ready for the next frame. The busy flag means a frame is being captured into the active buffer. In single-shot mode, a frame start consumes the armed buffer. With auto-arm set, the buffer stays armed and is reused until software commits a new one. Setting the force bit lets a commit stop a channel in the middle of a frame. Frame size, compression control, debug and frame-end ID words are plain storage in the same window. The datapath itself lies outside this block.

Top module: `capdma_bufregs`

## Requirements
- R1: After reset, every active value, every armed and busy flag, and every readable register is zero.
- R2: Writes to the length, stride, upper-address and control words only change the shadow copy. Reading such a word returns the value written, and the active outputs keep their old values.
- R3: On an idle channel, a write to the lower-address word (window offset 0x04) commits control, upper address (offset 0x14), stride (offset 0x08), length (offset 0x0C) and the new lower address to the active outputs one clock later. Armed then equals control bit 0, the enable bit.
- R4: A lower-address write while the channel is busy leaves the active outputs unchanged through the rest of the frame and through its frame end. The held set becomes active in the clock after the next frame-start pulse.
- R5: A second lower-address write made before that frame start replaces the held set, so the later values are the ones that become active.
- R6: A frame start on an armed, enabled channel sets busy. When control bit 4 (auto-arm) is clear, the same frame start clears armed. Armed never falls in a cycle that has neither a write nor a frame start.
- R7: With auto-arm set, armed stays set across frame starts, and the active buffer is reused unchanged.
- R8: A lower-address write whose shadow control has bit 3 (force) set commits at once, even in the middle of a frame. If bit 0 is clear in that control, busy and armed clear and any held set is dropped.
- R9: A frame-end pulse without a frame start clears busy one clock later.
- R10: The following addresses ignore writes and read as zero: window offsets 0x24 to 0x3C, addresses below 0x28, and addresses past the last channel window.
- R11: Channel windows are 0x40 apart and independent. Writes and frame pulses for one channel leave every other channel's registers and outputs unchanged.
- R12: Frame size (offset 0x18, height in bits 31:16, width in bits 15:0), compression control (offset 0x1C), debug (offset 0x10) and frame-end ID (offset 0x20) read back as written. The control word (offset 0x00) reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| frame_start | input | NUM_CH | Per-channel frame-start pulse |
| frame_end | input | NUM_CH | Per-channel frame-end pulse |
| act_addr | output | NUM_CH x 64 | Active buffer address {upper, lower}, 16-byte units |
| act_stride | output | NUM_CH x 32 | Active line stride, 16-byte units |
| act_len | output | NUM_CH x 32 | Active buffer length, 16-byte units |
| act_ctrl | output | NUM_CH x 32 | Active control word |
| armed | output | NUM_CH | Buffer ready for the next frame |
| busy | output | NUM_CH | Frame capture in progress |

## Verification
Every write, commit and frame pulse is captured on one rising edge. Active outputs, armed and busy change on that edge, and read data follows rd_addr in the same cycle. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and checks there, one edge after capture. For held commits, the bench checks the active outputs after the write and again after the frame end. It checks the new values only in the falling edge that follows the frame-start pulse.

// File: rtl/capdma_pkg.sv
package capdma_pkg;

    localparam int REG_W     = 32;
    localparam int CTL_EN    = 0;
    localparam int CTL_FORCE = 3;
    localparam int CTL_AUTO  = 4;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ADDR_LO,
        SEL_STRIDE,
        SEL_LEN,
        SEL_DEBUG,
        SEL_ADDR_HI,
        SEL_FSIZE,
        SEL_COMP,
        SEL_FEID
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] addr_hi;
        logic [REG_W-1:0] addr_lo;
        logic [REG_W-1:0] stride;
        logic [REG_W-1:0] len;
    } buf_set_t;

    function automatic reg_sel_e sel_of_offset(input logic [7:0] off);
        case (off)
            8'h00:   return SEL_CTRL;
            8'h04:   return SEL_ADDR_LO;
            8'h08:   return SEL_STRIDE;
            8'h0C:   return SEL_LEN;
            8'h10:   return SEL_DEBUG;
            8'h14:   return SEL_ADDR_HI;
            8'h18:   return SEL_FSIZE;
            8'h1C:   return SEL_COMP;
            8'h20:   return SEL_FEID;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/capdma_addr_dec.sv
module capdma_addr_dec
    import capdma_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_CH  = 4,
    parameter int CH_BASE = 'h28,
    parameter int CH_SPAN = 'h40,
    localparam int OFF_W  = $clog2(CH_SPAN),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch,
    output reg_sel_e          sel
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] ch_idx;
    logic              in_range;

    always_comb begin
        rel      = addr - ADDR_W'(CH_BASE);
        ch_idx   = rel >> OFF_W;
        in_range = (addr >= ADDR_W'(CH_BASE)) && (ch_idx < ADDR_W'(NUM_CH));
        ch       = ch_idx[CH_W-1:0];
        sel      = in_range ? sel_of_offset(8'(rel[OFF_W-1:0])) : SEL_NONE;
    end
endmodule

// File: rtl/capdma_chan.sv
module capdma_chan
    import capdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  reg_sel_e         rd_sel,
    input  logic             frame_start,
    input  logic             frame_end,
    output logic [REG_W-1:0] rd_word,
    output buf_set_t         act,
    output logic             armed,
    output logic             busy
);
    buf_set_t         shd_q, pend_q, act_q;
    logic             pend_v_q, armed_q, busy_q;
    logic [REG_W-1:0] dbg_q, fsize_q, comp_q, feid_q;

    buf_set_t nxt_act, nxt_pend, commit_set;
    logic     nxt_pend_v, nxt_armed, nxt_busy, arm_src, commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_q   <= '0;
            dbg_q   <= '0;
            fsize_q <= '0;
            comp_q  <= '0;
            feid_q  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL:    shd_q.ctrl    <= wr_data;
                SEL_ADDR_LO: shd_q.addr_lo <= wr_data;
                SEL_STRIDE:  shd_q.stride  <= wr_data;
                SEL_LEN:     shd_q.len     <= wr_data;
                SEL_ADDR_HI: shd_q.addr_hi <= wr_data;
                SEL_DEBUG:   dbg_q         <= wr_data;
                SEL_FSIZE:   fsize_q       <= wr_data;
                SEL_COMP:    comp_q        <= wr_data;
                SEL_FEID:    feid_q        <= wr_data;
                default:     ;
            endcase
        end
    end

    // Frame events are resolved first; a commit in the same cycle then
    // sees the busy state the frame start produced.
    always_comb begin
        nxt_act    = act_q;
        nxt_pend   = pend_q;
        nxt_pend_v = pend_v_q;
        nxt_armed  = armed_q;
        nxt_busy   = busy_q;
        arm_src    = armed_q;
        commit     = wr_en && (wr_sel == SEL_ADDR_LO);
        commit_set = shd_q;
        commit_set.addr_lo = wr_data;

        if (frame_start) begin
            if (pend_v_q) begin
                nxt_act    = pend_q;
                nxt_pend_v = 1'b0;
                arm_src    = 1'b1;
            end
            nxt_busy  = arm_src && nxt_act.ctrl[CTL_EN];
            nxt_armed = arm_src && nxt_act.ctrl[CTL_AUTO];
        end else if (frame_end) begin
            nxt_busy = 1'b0;
        end

        if (commit) begin
            if (!nxt_busy || commit_set.ctrl[CTL_FORCE]) begin
                nxt_act    = commit_set;
                nxt_pend_v = 1'b0;
                nxt_armed  = commit_set.ctrl[CTL_EN];
                nxt_busy   = nxt_busy && commit_set.ctrl[CTL_EN];
            end else begin
                nxt_pend   = commit_set;
                nxt_pend_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            armed_q  <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            act_q    <= nxt_act;
            pend_q   <= nxt_pend;
            pend_v_q <= nxt_pend_v;
            armed_q  <= nxt_armed;
            busy_q   <= nxt_busy;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_CTRL:    rd_word = shd_q.ctrl;
            SEL_ADDR_LO: rd_word = shd_q.addr_lo;
            SEL_STRIDE:  rd_word = shd_q.stride;
            SEL_LEN:     rd_word = shd_q.len;
            SEL_ADDR_HI: rd_word = shd_q.addr_hi;
            SEL_DEBUG:   rd_word = dbg_q;
            SEL_FSIZE:   rd_word = fsize_q;
            SEL_COMP:    rd_word = comp_q;
            SEL_FEID:    rd_word = feid_q;
            default:     rd_word = '0;
        endcase
    end

    assign act   = act_q;
    assign armed = armed_q;
    assign busy  = busy_q;
endmodule

// File: rtl/capdma_bufregs.sv
module capdma_bufregs
    import capdma_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_CH  = 4,
    parameter int CH_BASE = 'h28,
    parameter int CH_SPAN = 'h40,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [31:0]                    wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [31:0]                    rd_data,
    input  logic [NUM_CH-1:0]              frame_start,
    input  logic [NUM_CH-1:0]              frame_end,
    output logic [NUM_CH-1:0][63:0]        act_addr,
    output logic [NUM_CH-1:0][31:0]        act_stride,
    output logic [NUM_CH-1:0][31:0]        act_len,
    output logic [NUM_CH-1:0][31:0]        act_ctrl,
    output logic [NUM_CH-1:0]              armed,
    output logic [NUM_CH-1:0]              busy
);
    logic [CH_W-1:0]         wr_ch, rd_ch;
    reg_sel_e                wr_sel, rd_sel;
    logic [NUM_CH-1:0][31:0] rd_words;

    capdma_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .CH_SPAN(CH_SPAN))
        u_wr_dec (.addr(wr_addr), .ch(wr_ch), .sel(wr_sel));

    capdma_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .CH_SPAN(CH_SPAN))
        u_rd_dec (.addr(rd_addr), .ch(rd_ch), .sel(rd_sel));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        buf_set_t act;
        logic     hit;

        assign hit = wr_en && (wr_ch == CH_W'(i)) && (wr_sel != SEL_NONE);

        capdma_chan u_chan (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (hit),
            .wr_sel      (wr_sel),
            .wr_data     (wr_data),
            .rd_sel      (rd_sel),
            .frame_start (frame_start[i]),
            .frame_end   (frame_end[i]),
            .rd_word     (rd_words[i]),
            .act         (act),
            .armed       (armed[i]),
            .busy        (busy[i])
        );

        assign act_addr[i]   = {act.addr_hi, act.addr_lo};
        assign act_stride[i] = act.stride;
        assign act_len[i]    = act.len;
        assign act_ctrl[i]   = act.ctrl;
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel != SEL_NONE) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (rd_ch == CH_W'(i)) rd_data = rd_words[i];
            end
        end
    end
endmodule

// File: rtl/capdma_bufregs_chk.sv
module capdma_bufregs_chk #(
    parameter int NUM_CH = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [NUM_CH-1:0]       frame_start,
    input logic [NUM_CH-1:0]       frame_end,
    input logic [NUM_CH-1:0][63:0] act_addr,
    input logic [NUM_CH-1:0]       armed,
    input logic [NUM_CH-1:0]       busy
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (armed == '0 && busy == '0 && act_addr == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R9
        frame_end_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (frame_end[i] && !frame_start[i]) |=> !busy[i]);

        // R6
        busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(busy[i]) |-> $past(frame_start[i]));

        // R6
        armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (armed[i] && !frame_start[i] && !wr_en) |=> armed[i]);

        // R4
        active_change_src_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(act_addr[i]) |-> $past(wr_en || frame_start[i]));

        // R3
        armed_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(armed[i]) |-> $past(wr_en || frame_start[i]));
    end
endmodule

bind capdma_bufregs capdma_bufregs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .act_addr    (act_addr),
    .armed       (armed),
    .busy        (busy)
);

// File: tb/capdma_bufregs_test.sv
module capdma_bufregs_test;
    localparam int ADDR_W = 12;
    localparam int NUM_CH = 4;
    localparam int BASE   = 'h28;
    localparam int SPAN   = 'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [NUM_CH-1:0] frame_start = '0;
    logic [NUM_CH-1:0] frame_end = '0;
    logic [NUM_CH-1:0][63:0] act_addr;
    logic [NUM_CH-1:0][31:0] act_stride, act_len, act_ctrl;
    logic [NUM_CH-1:0] armed, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    capdma_bufregs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(BASE), .CH_SPAN(SPAN)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start),
        .frame_end(frame_end), .act_addr(act_addr), .act_stride(act_stride),
        .act_len(act_len), .act_ctrl(act_ctrl), .armed(armed), .busy(busy)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_raw(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int ch, input int off, input logic [31:0] d);
        wr_raw(BASE + ch * SPAN + off, d);
    endtask

    task automatic rd_raw_chk(input string req, input int a, input logic [31:0] exp);
        rd_addr = ADDR_W'(a);
        #1;
        check(req, 64'(rd_data), 64'(exp));
    endtask

    task automatic rd_chk(input string req, input int ch, input int off, input logic [31:0] exp);
        rd_raw_chk(req, BASE + ch * SPAN + off, exp);
    endtask

    task automatic fs(input int ch);
        @(negedge clk); frame_start[ch] = 1'b1;
        @(negedge clk); frame_start[ch] = 1'b0;
    endtask

    task automatic fe(input int ch);
        @(negedge clk); frame_end[ch] = 1'b1;
        @(negedge clk); frame_end[ch] = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 armed", 64'(armed), 0);
        check("R1 busy", 64'(busy), 0);
        check("R1 act_addr", act_addr[0], 0);
        check("R1 act_len", 64'(act_len[3]), 0);
        rd_chk("R1 ctrl read", 0, 'h00, 0);
    endtask

    task automatic t_idle_commit();
        wr(0, 'h00, 32'h1);
        wr(0, 'h0C, 32'h100);
        wr(0, 'h08, 32'h20);
        wr(0, 'h14, 32'h1);
        check("R2 act_len before commit", 64'(act_len[0]), 0);
        check("R2 act_ctrl before commit", 64'(act_ctrl[0]), 0);
        rd_chk("R2 len readback", 0, 'h0C, 32'h100);
        wr(0, 'h04, 32'h5000);
        check("R3 act_addr", act_addr[0], 64'h1_0000_5000);
        check("R3 act_len", 64'(act_len[0]), 'h100);
        check("R3 act_stride", 64'(act_stride[0]), 'h20);
        check("R3 armed", 64'(armed[0]), 1);
        check("R3 busy", 64'(busy[0]), 0);
    endtask

    task automatic t_single_shot();
        fs(0);
        check("R6 busy after start", 64'(busy[0]), 1);
        check("R6 armed consumed", 64'(armed[0]), 0);
        fe(0);
        check("R9 busy after end", 64'(busy[0]), 0);
    endtask

    task automatic t_pending();
        wr(0, 'h04, 32'h6000);
        check("R3 recommit idle", act_addr[0], 64'h1_0000_6000);
        check("R3 rearmed", 64'(armed[0]), 1);
        fs(0);
        check("R6 busy", 64'(busy[0]), 1);
        wr(0, 'h0C, 32'h200);
        wr(0, 'h04, 32'h7000);
        check("R4 held addr", act_addr[0], 64'h1_0000_6000);
        check("R4 held len", 64'(act_len[0]), 'h100);
        wr(0, 'h0C, 32'h300);
        wr(0, 'h04, 32'h8000);
        fe(0);
        check("R4 held after end", act_addr[0], 64'h1_0000_6000);
        check("R9 busy cleared", 64'(busy[0]), 0);
        fs(0);
        check("R5 replaced addr", act_addr[0], 64'h1_0000_8000);
        check("R5 replaced len", 64'(act_len[0]), 'h300);
        check("R4 busy on pending start", 64'(busy[0]), 1);
        check("R6 armed after start", 64'(armed[0]), 0);
        wr(0, 'h0C, 32'h999);
        check("R2 len shadow only", 64'(act_len[0]), 'h300);
    endtask

    task automatic t_force_stop();
        wr(0, 'h00, 32'h8);
        check("R2 ctrl shadow only", 64'(act_ctrl[0]), 1);
        check("R8 still busy before commit", 64'(busy[0]), 1);
        wr(0, 'h04, 32'h0);
        check("R8 busy stopped", 64'(busy[0]), 0);
        check("R8 armed cleared", 64'(armed[0]), 0);
        check("R8 act_ctrl", 64'(act_ctrl[0]), 'h8);
        check("R8 act_addr", act_addr[0], 64'h1_0000_0000);
        check("R8 act_len", 64'(act_len[0]), 'h999);
        fs(0);
        check("R8 no restart", 64'(busy[0]), 0);
    endtask

    task automatic t_auto_arm();
        wr(1, 'h00, 32'h11);
        wr(1, 'h08, 32'h40);
        wr(1, 'h0C, 32'h80);
        wr(1, 'h04, 32'h100);
        check("R3 ch1 armed", 64'(armed[1]), 1);
        fs(1);
        check("R7 busy", 64'(busy[1]), 1);
        check("R7 armed kept", 64'(armed[1]), 1);
        fe(1);
        fs(1);
        check("R7 armed again", 64'(armed[1]), 1);
        check("R7 busy again", 64'(busy[1]), 1);
        check("R7 buffer reused", act_addr[1], 64'h100);
        check("R11 ch0 untouched", act_addr[0], 64'h1_0000_0000);
        check("R11 ch0 idle", 64'(busy[0]), 0);
    endtask

    task automatic t_undefined();
        wr(1, 'h24, 32'hDEAD);
        rd_chk("R10 hole 0x24", 1, 'h24, 0);
        wr(0, 'h3C, 32'hBEEF);
        rd_chk("R10 hole 0x3C", 0, 'h3C, 0);
        wr_raw('h10, 32'h1234);
        rd_raw_chk("R10 below base", 'h10, 0);
        wr_raw(BASE + NUM_CH * SPAN, 32'h5678);
        rd_raw_chk("R10 past last", BASE + NUM_CH * SPAN, 0);
        rd_chk("R10 ch0 ctrl kept", 0, 'h00, 32'h8);
        check("R10 ch1 armed kept", 64'(armed[1]), 1);
        check("R10 ch1 addr kept", act_addr[1], 64'h100);
    endtask

    task automatic t_plain();
        wr(2, 'h00, 32'h7003_E0A5);
        rd_chk("R12 ctrl readback", 2, 'h00, 32'h7003_E0A5);
        check("R2 ch2 act_ctrl", 64'(act_ctrl[2]), 0);
        wr(2, 'h18, 32'h0438_0780);
        wr(2, 'h1C, 32'h0305_0040);
        wr(2, 'h10, 32'h5A5A);
        wr(2, 'h20, 32'h77);
        wr(2, 'h14, 32'hABCD);
        rd_chk("R12 frame size", 2, 'h18, 32'h0438_0780);
        rd_chk("R12 compression", 2, 'h1C, 32'h0305_0040);
        rd_chk("R12 debug", 2, 'h10, 32'h5A5A);
        rd_chk("R12 frame-end id", 2, 'h20, 32'h77);
        rd_chk("R2 addr_hi readback", 2, 'h14, 32'hABCD);
        check("R2 ch2 act_addr", act_addr[2], 0);
        rd_chk("R11 ch3 ctrl", 3, 'h00, 0);
        rd_chk("R11 ch1 frame size", 1, 'h18, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_commit();
        t_single_shot();
        t_pending();
        t_force_stop();
        t_auto_arm();
        t_undefined();
        t_plain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule